// File: doc/BRIEF.md
# Program Fetch Router with Reset and Interrupt Vectoring

This block sits between a processor's fetch unit and its two program stores: a small on-chip ROM that covers the bottom 4 KB of a 64 KB code space, and an external program bus. For every fetch request it decides which store supplies the byte. For external fetches it pulses an active-low program strobe and drives the full 16-bit address. One cycle after the strobe cycle it returns the chosen byte.

The split between the two stores depends on a board-level access pin. When the pin is high, the low 4 KB come from the on-chip ROM and everything above comes from outside. When the pin is low, all fetches go outside, including the low 4 KB. The pin is captured once, on the first clock after reset is released, and held from then on.

The block also supplies the redirect targets for the fetch unit. While reset is asserted, and in the first cycle after it is released, it presents address 0000h. When an interrupt is taken it presents the entry address of the source. Entry addresses start at 0003h and are spaced eight bytes apart, one per source.

Top module: `pfetch_router`

## Requirements
- R1: If the latched access pin is 1 and a request address is below 1000h, then in the next cycle `rom_sel` is 1, `rom_addr` equals the low 12 address bits, and `ext_strobe_n` stays 1.
- R2: If the latched access pin is 1 and a request address is 1000h or above, then in the next cycle `ext_strobe_n` is 0, `ext_addr` equals the request address, and `rom_sel` is 0.
- R3: If the latched access pin is 0, every request is external, including addresses 0000h to 0FFFh.
- R4: Each request produces exactly one strobe cycle: either `rom_sel` high or `ext_strobe_n` low, never both. With no request the strobe stays 1.
- R5: Two cycles after a request, `fetch_valid` is 1 for one cycle. At that point `fetch_data` holds the byte the selected source drove during the strobe cycle: `rom_data` for internal fetches, `ext_data` for external ones.
- R6: The access pin is sampled on the first clock edge after reset release. Later changes to the pin do not change the routing.
- R7: While reset is asserted, and in the first cycle after release, `redirect_valid` is 1 and `redirect_addr` is 0000h. After that `redirect_valid` is 0 unless an interrupt vector is pending.
- R8: If `irq_take` is 1 with `irq_idx` = n, where n is 0 to 5, then in the next cycle `redirect_valid` is 1 and `redirect_addr` is 8·n + 3. Index 0, the external interrupt, gives 0003h.
- R9: If `irq_take` is 1 with `irq_idx` of 6 or 7, the request is ignored and no redirect follows.
- R10: During reset, `ext_strobe_n` is 1, and `rom_sel` and `fetch_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_access_pin | input | 1 | Board pin: 1 maps the low 4 KB to on-chip ROM |
| fetch_req | input | 1 | Fetch request for `fetch_addr` |
| fetch_addr | input | 16 | Fetch address |
| irq_take | input | 1 | An interrupt is being entered |
| irq_idx | input | 3 | Source index of the interrupt taken |
| rom_data | input | 8 | Byte from on-chip ROM at `rom_addr` |
| ext_data | input | 8 | Byte from the external program bus |
| rom_sel | output | 1 | On-chip ROM read select for this cycle |
| rom_addr | output | 12 | On-chip ROM byte address |
| ext_strobe_n | output | 1 | Active-low external program read strobe |
| ext_addr | output | 16 | External program address |
| fetch_valid | output | 1 | `fetch_data` holds a fetched byte |
| fetch_data | output | 8 | Fetched byte |
| redirect_valid | output | 1 | `redirect_addr` is a reset or interrupt target |
| redirect_addr | output | 16 | Reset start address or interrupt entry address |

## Verification
The assertions assume that the request, interrupt and address inputs are low or stable while reset is asserted. Antecedents that refer to the previous cycle are therefore qualified by reset having been released in that cycle. They also assume that the fetch unit never takes an interrupt in the same cycle as the reset redirect. The bench changes inputs only on falling clock edges and keeps `fetch_req` and `irq_take` low across every reset and its first cycle. It models both stores as address-dependent functions, so that a byte taken from the wrong source is visible.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;

  // Default geometry of the program space
  localparam int PF_ADDR_W     = 16;
  localparam int PF_DATA_W     = 8;
  localparam int PF_ROM_BYTES  = 4096;
  localparam int PF_NUM_VEC    = 6;
  localparam int PF_VEC_BASE   = 3;
  localparam int PF_VEC_STRIDE = 8;
  localparam int PF_RESET_ADDR = 0;

  // Where a fetch is served from
  typedef enum logic {
    SRC_EXTERNAL = 1'b0,
    SRC_ONCHIP   = 1'b1
  } fetch_src_e;

  // One pipeline slot of the fetch stage
  typedef struct packed {
    logic       busy;
    fetch_src_e src;
  } fetch_slot_t;

  // An address is served on-chip only when the low region is mapped
  // on-chip and the address lies below the on-chip ROM size.
  function automatic fetch_src_e route_of(input logic [31:0] addr,
                                          input logic        onchip_low,
                                          input logic [31:0] rom_bytes);
    if (onchip_low && (addr < rom_bytes)) return SRC_ONCHIP;
    return SRC_EXTERNAL;
  endfunction

  // Entry address of interrupt source n
  function automatic int unsigned entry_of(input int unsigned n,
                                           input int unsigned base,
                                           input int unsigned stride);
    return base + stride * n;
  endfunction

endpackage

// File: rtl/pfr_boot_latch.sv
module pfr_boot_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_level,
  output logic boot_done,
  output logic pin_latched,
  output logic onchip_low
);
  logic done_q;
  logic pin_q;

  // Capture the pin on the first edge after reset release, then hold it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pin_q  <= 1'b0;
    end else if (!done_q) begin
      done_q <= 1'b1;
      pin_q  <= pin_level;
    end
  end

  assign boot_done   = done_q;
  assign pin_latched = pin_q;
  // Before the capture edge the live level is the one about to be latched.
  assign onchip_low  = done_q ? pin_q : pin_level;

endmodule

// File: rtl/pfr_region_decode.sv
module pfr_region_decode
  import pfetch_pkg::*;
#(
  parameter int ADDR_W    = PF_ADDR_W,
  parameter int ROM_BYTES = PF_ROM_BYTES
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              onchip_low,
  output fetch_src_e        src,
  output logic              in_low_region
);
  localparam logic [31:0] ROM_LIMIT = 32'(ROM_BYTES);

  assign in_low_region = (32'(addr) < ROM_LIMIT);
  assign src           = route_of(32'(addr), onchip_low, ROM_LIMIT);

endmodule

// File: rtl/pfr_vector_gen.sv
module pfr_vector_gen
  import pfetch_pkg::*;
#(
  parameter int ADDR_W     = PF_ADDR_W,
  parameter int NUM_VEC    = PF_NUM_VEC,
  parameter int VEC_BASE   = PF_VEC_BASE,
  parameter int VEC_STRIDE = PF_VEC_STRIDE,
  parameter int RESET_ADDR = PF_RESET_ADDR,
  localparam int IDX_W     = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_done,
  input  logic              irq_take,
  input  logic [IDX_W-1:0]  irq_idx,
  output logic              idx_in_range,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr
);
  logic [ADDR_W-1:0] vec_tbl [NUM_VEC];
  logic [ADDR_W-1:0] vec_sel;
  logic              hit;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;

  // One entry per source, computed from base and stride
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    assign vec_tbl[g] = ADDR_W'(entry_of(g, VEC_BASE, VEC_STRIDE));
  end

  always_comb begin
    hit     = 1'b0;
    vec_sel = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (irq_idx == IDX_W'(i)) begin
        hit     = 1'b1;
        vec_sel = vec_tbl[i];
      end
    end
  end

  assign idx_in_range = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      pend_q <= irq_take && hit;
      if (irq_take && hit) addr_q <= vec_sel;
    end
  end

  // The reset start address wins until the boot capture edge.
  assign redirect_valid = !boot_done || pend_q;
  assign redirect_addr  = boot_done ? addr_q : ADDR_W'(RESET_ADDR);

endmodule

// File: rtl/pfr_fetch_stage.sv
module pfr_fetch_stage
  import pfetch_pkg::*;
#(
  parameter int ADDR_W = PF_ADDR_W,
  parameter int DATA_W = PF_DATA_W,
  parameter int ROM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  fetch_src_e        src,
  input  logic [DATA_W-1:0] rom_data,
  input  logic [DATA_W-1:0] ext_data,
  output logic              rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ext_strobe_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              fetch_valid,
  output logic [DATA_W-1:0] fetch_data
);
  fetch_slot_t       slot_q;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  // Strobe cycle: one cycle after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '{busy: 1'b0, src: SRC_EXTERNAL};
      addr_q <= '0;
    end else begin
      slot_q.busy <= req;
      if (req) begin
        slot_q.src <= src;
        addr_q     <= addr;
      end
    end
  end

  // Data cycle: the byte seen during the strobe cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= slot_q.busy;
      if (slot_q.busy) data_q <= (slot_q.src == SRC_ONCHIP) ? rom_data : ext_data;
    end
  end

  assign rom_sel      = slot_q.busy && (slot_q.src == SRC_ONCHIP);
  assign ext_strobe_n = !(slot_q.busy && (slot_q.src == SRC_EXTERNAL));
  assign rom_addr     = addr_q[ROM_AW-1:0];
  assign ext_addr     = addr_q;
  assign fetch_valid  = valid_q;
  assign fetch_data   = data_q;

endmodule

// File: rtl/pfetch_router.sv
module pfetch_router
  import pfetch_pkg::*;
#(
  parameter int ADDR_W     = PF_ADDR_W,
  parameter int DATA_W     = PF_DATA_W,
  parameter int ROM_BYTES  = PF_ROM_BYTES,
  parameter int NUM_VEC    = PF_NUM_VEC,
  parameter int VEC_BASE   = PF_VEC_BASE,
  parameter int VEC_STRIDE = PF_VEC_STRIDE,
  localparam int IDX_W     = $clog2(NUM_VEC),
  localparam int ROM_AW    = $clog2(ROM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_access_pin,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              irq_take,
  input  logic [IDX_W-1:0]  irq_idx,
  input  logic [DATA_W-1:0] rom_data,
  input  logic [DATA_W-1:0] ext_data,
  output logic              rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ext_strobe_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              fetch_valid,
  output logic [DATA_W-1:0] fetch_data,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr
);
  // Named internal events, observed by the bound checker
  logic       boot_done;
  logic       ea_latched;
  logic       onchip_low;
  fetch_src_e req_src;
  logic       req_low_region;
  logic       irq_idx_ok;

  pfr_boot_latch u_boot (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_level   (ext_access_pin),
    .boot_done   (boot_done),
    .pin_latched (ea_latched),
    .onchip_low  (onchip_low)
  );

  pfr_region_decode #(
    .ADDR_W    (ADDR_W),
    .ROM_BYTES (ROM_BYTES)
  ) u_decode (
    .addr          (fetch_addr),
    .onchip_low    (onchip_low),
    .src           (req_src),
    .in_low_region (req_low_region)
  );

  pfr_fetch_stage #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ROM_AW (ROM_AW)
  ) u_stage (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (fetch_req),
    .addr         (fetch_addr),
    .src          (req_src),
    .rom_data     (rom_data),
    .ext_data     (ext_data),
    .rom_sel      (rom_sel),
    .rom_addr     (rom_addr),
    .ext_strobe_n (ext_strobe_n),
    .ext_addr     (ext_addr),
    .fetch_valid  (fetch_valid),
    .fetch_data   (fetch_data)
  );

  pfr_vector_gen #(
    .ADDR_W     (ADDR_W),
    .NUM_VEC    (NUM_VEC),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE),
    .RESET_ADDR (PF_RESET_ADDR)
  ) u_vec (
    .clk            (clk),
    .rst_n          (rst_n),
    .boot_done      (boot_done),
    .irq_take       (irq_take),
    .irq_idx        (irq_idx),
    .idx_in_range   (irq_idx_ok),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr)
  );

endmodule

// File: rtl/pfetch_router_chk.sv
module pfetch_router_chk #(
  parameter int ADDR_W     = 16,
  parameter int IDX_W      = 3,
  parameter int ROM_BYTES  = 4096,
  parameter int NUM_VEC    = 6,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              irq_take,
  input logic [IDX_W-1:0]  irq_idx,
  input logic              rom_sel,
  input logic              ext_strobe_n,
  input logic              fetch_valid,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_addr,
  input logic              boot_done,
  input logic              ea_latched
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(ROM_BYTES);

  AST_ONCHIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(fetch_req) && ea_latched && ($past(fetch_addr) < LIMIT)
      |-> rom_sel && ext_strobe_n); // R1

  AST_EXT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(fetch_req) && ($past(fetch_addr) >= LIMIT)
      |-> !ext_strobe_n && !rom_sel); // R2

  AST_EXT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(fetch_req) && !ea_latched |-> !ext_strobe_n); // R3

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, !ext_strobe_n})); // R4

  AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(fetch_req) |-> ext_strobe_n && !rom_sel); // R4

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && fetch_valid |-> $past(rom_sel || !ext_strobe_n)); // R5

  AST_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(boot_done) |-> $stable(ea_latched)); // R6

  AST_BOOT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> redirect_valid && (redirect_addr == '0)); // R7

  AST_VECTOR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(boot_done) && $past(irq_take) && ($past(irq_idx) < IDX_W'(NUM_VEC))
      |-> redirect_valid &&
          (redirect_addr == ADDR_W'($past(irq_idx)) * ADDR_W'(VEC_STRIDE) + ADDR_W'(VEC_BASE))); // R8

  AST_VECTOR_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(boot_done) && $past(irq_take) && ($past(irq_idx) >= IDX_W'(NUM_VEC))
      |-> !redirect_valid); // R9

  always_comb begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (ext_strobe_n && !rom_sel && !fetch_valid); // R10
    end
  end

endmodule

bind pfetch_router pfetch_router_chk #(
  .ADDR_W     (ADDR_W),
  .IDX_W      (IDX_W),
  .ROM_BYTES  (ROM_BYTES),
  .NUM_VEC    (NUM_VEC),
  .VEC_BASE   (VEC_BASE),
  .VEC_STRIDE (VEC_STRIDE)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_req      (fetch_req),
  .fetch_addr     (fetch_addr),
  .irq_take       (irq_take),
  .irq_idx        (irq_idx),
  .rom_sel        (rom_sel),
  .ext_strobe_n   (ext_strobe_n),
  .fetch_valid    (fetch_valid),
  .redirect_valid (redirect_valid),
  .redirect_addr  (redirect_addr),
  .boot_done      (boot_done),
  .ea_latched     (ea_latched)
);

// File: tb/tb_pfetch_router.sv
module tb_pfetch_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_access_pin = 1'b1;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        irq_take = 1'b0;
  logic [2:0]  irq_idx = '0;
  logic [7:0]  rom_data;
  logic [7:0]  ext_data;
  logic        rom_sel;
  logic [11:0] rom_addr;
  logic        ext_strobe_n;
  logic [15:0] ext_addr;
  logic        fetch_valid;
  logic [7:0]  fetch_data;
  logic        redirect_valid;
  logic [15:0] redirect_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pfetch_router dut (
    .clk(clk), .rst_n(rst_n), .ext_access_pin(ext_access_pin),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .irq_take(irq_take), .irq_idx(irq_idx),
    .rom_data(rom_data), .ext_data(ext_data),
    .rom_sel(rom_sel), .rom_addr(rom_addr),
    .ext_strobe_n(ext_strobe_n), .ext_addr(ext_addr),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
  );

  // Store models: bytes depend on address so a wrong source shows up
  function automatic logic [7:0] rom_byte(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], 4'h3};
  endfunction
  function automatic logic [7:0] ext_byte(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'hC6;
  endfunction
  assign rom_data = rom_byte(rom_addr);
  assign ext_data = ext_strobe_n ? 8'h00 : ext_byte(ext_addr);

  typedef struct {
    bit          onchip;
    logic [15:0] addr;
    logic [7:0]  byte_v;
    string       req;
  } exp_t;
  exp_t src_q[$];
  exp_t data_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: one request, expectation pushed into the scoreboard
  task automatic fetch1(input logic [15:0] a, input bit onchip, input string req);
    exp_t e;
    e.onchip = onchip;
    e.addr   = a;
    e.byte_v = onchip ? rom_byte(a[11:0]) : ext_byte(a);
    e.req    = req;
    src_q.push_back(e);
    data_q.push_back(e);
    fetch_req  = 1'b1;
    fetch_addr = a;
    @(negedge clk);
    fetch_req  = 1'b0;
  endtask

  // Monitor: strobe cycle and data cycle, sampled on falling edges
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rom_sel || !ext_strobe_n) begin
        if (src_q.size() == 0) begin
          check(1'b0, "R4", "unexpected strobe", {30'd0, rom_sel, ext_strobe_n}, 32'h1);
        end else begin
          exp_t e;
          e = src_q.pop_front();
          if (e.onchip) begin
            check(rom_sel && ext_strobe_n, e.req, "on-chip select/strobe",
                  {30'd0, rom_sel, ext_strobe_n}, 32'h3);
            check(rom_addr == e.addr[11:0], e.req, "rom_addr", 32'(rom_addr), 32'(e.addr[11:0]));
          end else begin
            check(!rom_sel && !ext_strobe_n, e.req, "external select/strobe",
                  {30'd0, rom_sel, ext_strobe_n}, 32'h0);
            check(ext_addr == e.addr, e.req, "ext_addr", 32'(ext_addr), 32'(e.addr));
          end
        end
      end
      if (fetch_valid) begin
        if (data_q.size() == 0) begin
          check(1'b0, "R5", "unexpected fetch_valid", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = data_q.pop_front();
          check(fetch_data == e.byte_v, "R5", "fetch_data", 32'(fetch_data), 32'(e.byte_v));
        end
      end
    end
  end

  task automatic take_irq(input int n, input bit expect_hit, input logic [15:0] exp_addr,
                          input string req);
    irq_take = 1'b1;
    irq_idx  = 3'(n);
    @(negedge clk);
    irq_take = 1'b0;
    check(redirect_valid == expect_hit, req, "redirect_valid", 32'(redirect_valid), 32'(expect_hit));
    if (expect_hit)
      check(redirect_addr == exp_addr, req, "vector address", 32'(redirect_addr), 32'(exp_addr));
    @(negedge clk);
  endtask

  task automatic do_reset(input bit pin);
    rst_n = 1'b0;
    ext_access_pin = pin;
    repeat (3) @(negedge clk);
    // R10: outputs idle during reset
    check(ext_strobe_n && !rom_sel && !fetch_valid, "R10", "reset outputs",
          {29'd0, ext_strobe_n, rom_sel, fetch_valid}, 32'h4);
    check(redirect_valid && redirect_addr == 16'h0000, "R7", "redirect in reset",
          {15'd0, redirect_valid, redirect_addr}, 32'h10000);
    rst_n = 1'b1;
    #1;
    check(redirect_valid && redirect_addr == 16'h0000, "R7", "redirect first cycle",
          {15'd0, redirect_valid, redirect_addr}, 32'h10000);
    @(negedge clk);
    check(!redirect_valid, "R7", "redirect drops after boot", 32'(redirect_valid), 32'h0);
  endtask

  task automatic drain;
    repeat (4) @(negedge clk);
    check(src_q.size() == 0 && data_q.size() == 0, "R4", "scoreboard drained",
          32'(src_q.size() + data_q.size()), 32'h0);
    check(ext_strobe_n && !rom_sel, "R4", "idle strobe",
          {30'd0, ext_strobe_n, rom_sel}, 32'h2);
  endtask

  initial begin
    @(negedge clk);
    // Low region on-chip
    do_reset(1'b1);
    fetch1(16'h0000, 1'b1, "R1");
    fetch1(16'h0FFF, 1'b1, "R1");
    fetch1(16'h1000, 1'b0, "R2");
    fetch1(16'hFFFF, 1'b0, "R2");
    fetch1(16'h0ABC, 1'b1, "R1");
    fetch1(16'h2000, 1'b0, "R2");
    fetch1(16'h2001, 1'b0, "R2");
    @(negedge clk);
    fetch1(16'h8421, 1'b0, "R4");
    drain();
    // R6: pin change after boot has no effect
    ext_access_pin = 1'b0;
    @(negedge clk);
    fetch1(16'h0010, 1'b1, "R6");
    drain();
    // R8: all vectors, R9: out of range indices
    take_irq(0, 1'b1, 16'h0003, "R8");
    take_irq(1, 1'b1, 16'h000B, "R8");
    take_irq(2, 1'b1, 16'h0013, "R8");
    take_irq(3, 1'b1, 16'h001B, "R8");
    take_irq(4, 1'b1, 16'h0023, "R8");
    take_irq(5, 1'b1, 16'h002B, "R8");
    take_irq(6, 1'b0, 16'h0000, "R9");
    take_irq(7, 1'b0, 16'h0000, "R9");
    // All external
    do_reset(1'b0);
    fetch1(16'h0000, 1'b0, "R3");
    fetch1(16'h0FFF, 1'b0, "R3");
    fetch1(16'h8000, 1'b0, "R3");
    drain();
    ext_access_pin = 1'b1;
    @(negedge clk);
    fetch1(16'h0001, 1'b0, "R6");
    drain();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule